// File: doc/BRIEF.md
# RTC Periodic Interrupt Rate Generator

This block turns a 32768 Hz clock-enable into the slow timing events of a real-time clock. A 15-stage binary counter advances on every enable pulse. A programmable tap on that counter produces a one-cycle periodic event and a square-wave level. The final stage gives a one-second tick to the timekeeping logic.

A 7-bit control register selects the periodic rate in its low four bits and the counter operating mode in bits 6:4. The counter can be stopped, run normally, run in a test mode (treated as normal here) or held at zero. While it is held at zero the block flags this to the timekeeping logic. After release, the first second tick arrives half a second later, so software can align the start of a second.

The rate codes follow a fixed rule. Codes 3 to 15 give 32768 >> (code-1) Hz. Codes 1 and 2 alias to codes 8 and 9. Code 0 silences both the event and the square wave. Changing the rate never touches the counter, so the one-second tick stays in step.

Top module: `rtc_rate_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `reg_a_q` reads 7'h26 (rate code 6, chain mode 2), and `periodic_pulse`, `sqw_out`, `sec_tick` and `chain_in_reset` are all low.
- R2: Let the effective code `e` be between 3 and 15 and let the chain be running. Take a clock edge at which `tick_in` is high and the counter's new value is a multiple of 2^(e-1). After that edge, `periodic_pulse` is high for exactly one cycle. It is never high in two consecutive cycles.
- R3: Rate codes 1 and 2 behave exactly like codes 8 and 9.
- R4: While rate code 0 is selected, `periodic_pulse` and `sqw_out` stay low.
- R5: `periodic_pulse` is produced only while `pie_en` is high at the advancing edge.
- R6: While `sqw_en` is high and the rate code is nonzero, `sqw_out` equals bit e-2 of the counter. This gives a 50% duty square wave at the periodic frequency. While `sqw_en` is low, `sqw_out` is low.
- R7: Chain modes 0 and 1 (bits 6:4 of the register) freeze the counter. No periodic event and no second tick is produced. Counting resumes from the frozen value when the mode returns to 2.
- R8: Chain modes 6 and 7 hold the counter at zero, raise `chain_in_reset` and suppress `sec_tick`. After a change to mode 2, the first `sec_tick` follows the 16384th enable pulse.
- R9: Chain modes 3, 4 and 5 count exactly like mode 2.
- R10: While the chain runs, `sec_tick` pulses once every 32768 enable pulses and only after an edge with `tick_in` high. Writes to the rate field do not shift it.
- R11: When `ctrl_we` is high, `ctrl_wdata` is loaded into the register at the edge. The new value shows on `reg_a_q` the next cycle and governs the following edges. Bits 3:0 are the rate code and bits 6:4 are the chain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | 32768 Hz single-cycle enable |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control register write data |
| pie_en | input | 1 | Periodic event enable |
| sqw_en | input | 1 | Square-wave enable |
| reg_a_q | output | 7 | Current control register value |
| periodic_pulse | output | 1 | One-cycle periodic event |
| sqw_out | output | 1 | Square-wave level |
| sec_tick | output | 1 | One-cycle one-second tick |
| chain_in_reset | output | 1 | Counter held at zero |

## Verification
The properties assume `tick_in` is a synchronous enable that is sampled only at clock edges. They also assume that reset is applied for at least one edge before any check counts. Gating and reset properties compare outputs with the control value one edge earlier, because every output is registered from the register value in force before the write. The bench changes inputs only on falling edges and keeps writes on cycles without an enable pulse, so each register value is stable across the edge it governs.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_RUN  = 2'd1,
    CH_TEST = 2'd2,
    CH_HOLD = 2'd3
  } chain_mode_e;

  // Chain control codes: 0,1 off; 2 run; 3..5 test; 6,7 hold at zero
  function automatic chain_mode_e decode_chain(input logic [2:0] code);
    chain_mode_e m;
    case (code)
      3'd0, 3'd1:       m = CH_OFF;
      3'd2:             m = CH_RUN;
      3'd3, 3'd4, 3'd5: m = CH_TEST;
      default:          m = CH_HOLD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int RATE_W    = 4,
  parameter int CHAIN_W   = 3,
  parameter int RATE_RST  = 6,
  parameter int CHAIN_RST = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [RATE_W+CHAIN_W-1:0] wdata,
  output logic [RATE_W-1:0]         rate_q,
  output logic [CHAIN_W-1:0]        chain_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= RATE_W'(RATE_RST);
      chain_q <= CHAIN_W'(CHAIN_RST);
    end else if (we) begin
      rate_q  <= wdata[RATE_W-1:0];
      chain_q <= wdata[RATE_W+CHAIN_W-1:RATE_W];
    end
  end

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_rate_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] cnt_nxt,
  output logic              adv,
  output logic              sec_q
);

  localparam logic [STAGES-1:0] HALF = {1'b1, {(STAGES-1){1'b0}}};

  logic [STAGES-1:0] cnt_q;
  logic              running;

  assign running = (mode == CH_RUN) || (mode == CH_TEST);
  assign adv     = tick_in && running;

  always_comb begin
    if (mode == CH_HOLD)
      cnt_nxt = '0;
    else if (adv)
      cnt_nxt = cnt_q + 1'b1;
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sec_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      sec_q <= adv && (cnt_nxt == HALF);
    end
  end

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic [STAGES-1:0] cnt_nxt,
  input  logic              adv,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              pulse_q,
  output logic              sqw_q
);

  localparam int NRATE     = 1 << RATE_W;
  localparam int ALIAS_OFS = 7;

  logic [NRATE-1:0]  hit;
  logic [NRATE-1:0]  lvl;
  logic [RATE_W-1:0] eff;
  logic              active;

  // Codes 1 and 2 roll over to the slow codes 8 and 9
  always_comb begin
    if (rate == RATE_W'(1) || rate == RATE_W'(2))
      eff = rate + RATE_W'(ALIAS_OFS);
    else
      eff = rate;
  end

  assign active = (rate != '0);

  for (genvar g = 0; g < NRATE; g++) begin : g_tap
    if (g >= 3 && g <= STAGES + 1) begin : g_live
      assign hit[g] = ~|cnt_nxt[g-2:0];
      assign lvl[g] = cnt_nxt[g-2];
    end else begin : g_dead
      assign hit[g] = 1'b0;
      assign lvl[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      sqw_q   <= 1'b0;
    end else begin
      pulse_q <= adv && pie_en && active && hit[eff];
      sqw_q   <= sqw_en && active && lvl[eff];
    end
  end

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_rate_pkg::*;
#(
  parameter int RATE_W  = 4,
  parameter int CHAIN_W = 3,
  parameter int STAGES  = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_in,
  input  logic                      ctrl_we,
  input  logic [RATE_W+CHAIN_W-1:0] ctrl_wdata,
  input  logic                      pie_en,
  input  logic                      sqw_en,
  output logic [RATE_W+CHAIN_W-1:0] reg_a_q,
  output logic                      periodic_pulse,
  output logic                      sqw_out,
  output logic                      sec_tick,
  output logic                      chain_in_reset
);

  logic [RATE_W-1:0]  rate_q;
  logic [CHAIN_W-1:0] chain_q;
  logic [STAGES-1:0]  cnt_nxt;
  logic               adv;
  chain_mode_e        mode;

  rtc_ctrl_reg #(
    .RATE_W   (RATE_W),
    .CHAIN_W  (CHAIN_W),
    .RATE_RST (6),
    .CHAIN_RST(2)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .we     (ctrl_we),
    .wdata  (ctrl_wdata),
    .rate_q (rate_q),
    .chain_q(chain_q)
  );

  assign mode = decode_chain(chain_q[2:0]);

  rtc_div_chain #(.STAGES(STAGES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .tick_in(tick_in),
    .mode   (mode),
    .cnt_nxt(cnt_nxt),
    .adv    (adv),
    .sec_q  (sec_tick)
  );

  rtc_rate_tap #(.STAGES(STAGES), .RATE_W(RATE_W)) u_tap (
    .clk    (clk),
    .rst    (rst),
    .rate   (rate_q),
    .cnt_nxt(cnt_nxt),
    .adv    (adv),
    .pie_en (pie_en),
    .sqw_en (sqw_en),
    .pulse_q(periodic_pulse),
    .sqw_q  (sqw_out)
  );

  assign reg_a_q        = {chain_q, rate_q};
  assign chain_in_reset = (mode == CH_HOLD);

endmodule

// File: rtl/rtc_rate_gen_chk.sv
module rtc_rate_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_in,
  input logic       pie_en,
  input logic [6:0] reg_a_q,
  input logic       periodic_pulse,
  input logic       sqw_out,
  input logic       sec_tick,
  input logic       chain_in_reset
);

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    periodic_pulse |=> !periodic_pulse);

  // R5
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    periodic_pulse |-> $past(pie_en));

  // R4
  rate_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_a_q[3:0]) == 4'd0) |-> (!periodic_pulse && !sqw_out));

  // R7
  chain_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_a_q[6:5]) == 2'b00) |-> (!periodic_pulse && !sec_tick));

  // R8
  hold_no_second_chk: assert property (@(posedge clk) disable iff (rst)
    $past(chain_in_reset) |-> !sec_tick);

  // R10
  second_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(tick_in));

endmodule

bind rtc_rate_gen rtc_rate_gen_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick_in       (tick_in),
  .pie_en        (pie_en),
  .reg_a_q       (reg_a_q),
  .periodic_pulse(periodic_pulse),
  .sqw_out       (sqw_out),
  .sec_tick      (sec_tick),
  .chain_in_reset(chain_in_reset)
);

// File: tb/rtc_rate_gen_bench.sv
module rtc_rate_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [6:0] ctrl_wdata = '0;
  logic       pie_en = 1'b1;
  logic       sqw_en = 1'b1;
  logic [6:0] reg_a_q;
  logic       periodic_pulse, sqw_out, sec_tick, chain_in_reset;

  int  n_total = 0;
  int  n_bad   = 0;
  bit  done    = 0;

  // bench model state
  int  m_cnt = 0;
  int  m_reg = 'h26;
  int  pulses = 0;
  int  secs = 0;
  int  tick_no = 0;
  int  sec_at = -1;

  always #10 clk = ~clk;

  rtc_rate_gen u_rtc_rate_gen (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .pie_en(pie_en), .sqw_en(sqw_en),
    .reg_a_q(reg_a_q), .periodic_pulse(periodic_pulse), .sqw_out(sqw_out),
    .sec_tick(sec_tick), .chain_in_reset(chain_in_reset)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_of(input int r);
    if (r == 1 || r == 2) return r + 7;
    return r;
  endfunction

  // one clock: drives at falling edge, compares at next falling edge
  task automatic cyc(input bit t);
    int  r, ch, e, nc, per;
    bit  run, hold, ep, es, eq;
    tick_in = t;
    r    = m_reg & 15;
    ch   = (m_reg >> 4) & 7;
    e    = eff_of(r);
    run  = (ch >= 2 && ch <= 5);
    hold = (ch >= 6);
    if (hold) nc = 0;
    else if (run && t) nc = (m_cnt + 1) % 32768;
    else nc = m_cnt;
    per = (r != 0) ? (1 << (e - 1)) : 1;
    ep  = run && t && pie_en && (r != 0) && (nc % per == 0);
    es  = run && t && (nc == 16384);
    eq  = sqw_en && (r != 0) && (((nc >> (e - 2)) & 1) == 1);
    m_cnt = nc;
    if (ctrl_we) m_reg = ctrl_wdata;
    @(posedge clk);
    @(negedge clk);
    ctrl_we = 1'b0;
    if (run && t) tick_no++;
    chk(periodic_pulse == ep, "R2 pulse", periodic_pulse, ep);
    chk(sqw_out == eq, "R6 sqw", sqw_out, eq);
    chk(sec_tick == es, "R10 sec", sec_tick, es);
    chk(chain_in_reset == (((m_reg >> 4) & 7) >= 6), "R8 inrst", chain_in_reset,
        ((m_reg >> 4) & 7) >= 6);
    chk(reg_a_q == 7'(m_reg), "R11 reg", reg_a_q, m_reg);
    if (periodic_pulse) pulses++;
    if (sec_tick) begin
      secs++;
      sec_at = tick_no;
    end
  endtask

  task automatic wr(input int v);
    ctrl_we = 1'b1;
    ctrl_wdata = 7'(v);
    cyc(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_a_q == 7'h26, "R1 reg in reset", reg_a_q, 'h26);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_a_q == 7'h26, "R1 reg", reg_a_q, 'h26);
    chk({periodic_pulse, sqw_out, sec_tick, chain_in_reset} == 4'b0, "R1 outs",
        {periodic_pulse, sqw_out, sec_tick, chain_in_reset}, 0);

    // R2 R3 R4: sweep all rate codes, 1024 enable pulses each
    for (int r = 0; r < 16; r++) begin
      int e, exp_p;
      wr('h60 | r);
      wr('h20 | r);
      pulses = 0;
      for (int k = 0; k < 1024; k++) begin
        cyc(1'b1);
        if (r % 2 == 1) cyc(1'b0);
      end
      e = eff_of(r);
      exp_p = (r == 0) ? 0 : (1024 >> (e - 1));
      if (r == 0) chk(pulses == 0, "R4 rate0 pulses", pulses, 0);
      else if (r <= 2) chk(pulses == exp_p, "R3 alias pulses", pulses, exp_p);
      else chk(pulses == exp_p, "R2 pulse count", pulses, exp_p);
    end

    // R5: enable low blocks events
    wr('h63); wr('h23);
    pie_en = 1'b0; pulses = 0;
    for (int k = 0; k < 64; k++) cyc(1'b1);
    chk(pulses == 0, "R5 pie off", pulses, 0);
    pie_en = 1'b1;

    // R6: square wave disabled stays low
    sqw_en = 1'b0;
    for (int k = 0; k < 32; k++) cyc(1'b1);
    chk(sqw_out == 1'b0, "R6 sqw off", sqw_out, 0);
    sqw_en = 1'b1;

    // R9: test mode counts like normal
    wr('h63); wr('h43); pulses = 0;
    for (int k = 0; k < 64; k++) cyc(1'b1);
    chk(pulses == 16, "R9 test mode", pulses, 16);

    // R7: off mode freezes, then resumes
    wr('h03); pulses = 0; secs = 0;
    for (int k = 0; k < 64; k++) cyc(1'b1);
    chk(pulses == 0, "R7 off pulses", pulses, 0);
    wr('h23);
    for (int k = 0; k < 16; k++) cyc(1'b1);
    wr('h13);
    for (int k = 0; k < 16; k++) cyc(1'b1);

    // R8 R10: second tick alignment after release, rate writes between
    wr('h66);
    chk(chain_in_reset == 1'b1, "R8 hold flag", chain_in_reset, 1);
    secs = 0;
    for (int k = 0; k < 100; k++) cyc(1'b1);
    chk(secs == 0, "R8 no sec in hold", secs, 0);
    wr('h26);
    tick_no = 0; sec_at = -1;
    for (int k = 0; k < 16384; k++) begin
      if (k == 8000) wr('h23);
      cyc(1'b1);
    end
    chk(sec_at == 16384 && secs == 1, "R8 first sec", sec_at, 16384);
    for (int k = 0; k < 32768; k++) begin
      if (k == 10000) wr('h2F);
      if (k == 20000) wr('h21);
      cyc(1'b1);
    end
    chk(sec_at == 49152 && secs == 2, "R10 sec period", sec_at, 49152);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule